// File: doc/BRIEF.md
# Prioritized Trap and Abort Arbiter

This block gathers the trap and abort requests of a 16-bit minicomputer CPU core. Each of fifteen sources raises its request with a one-cycle set pulse. The request stays pending until it is serviced or wiped. The arbiter offers the highest-ranked pending request to the trap sequencer as a registered grant index and vector. It holds that offer until the sequencer acknowledges it. On the acknowledge cycle it clears the group of pending requests that the serviced source supersedes. It also raises the strobes that tell the memory-management unit to clear its instruction-tracking register and to capture the vector in its vector-capture register.

A kernel stack abort is a separate event input. It wipes the whole abort group and leaves only the red stack request pending. An external device interrupt, with its own vector, ranks below every trap. It is offered only when no trap is pending. A frozen flag from the memory-management unit suppresses both register strobes. Pushing the old PC and PSW and fetching the new ones are left to the sequencer.

Top module: `trap_arbiter`

## Requirements
- R1: After reset, valid_o, clr_mmr1_o and ld_mmr2_o are 0 and no grant is offered until a request arrives.
- R2: Source indices rank from highest (index 0) to lowest (index 14): 0 red stack, 1 odd address, 2 nonexistent memory, 3 memory management, 4 parity, 5 privileged instruction, 6 illegal instruction, 7 breakpoint, 8 IOT, 9 EMT, 10 TRAP, 11 trace, 12 yellow stack, 13 power fail, 14 floating-point. The lowest pending index is granted. Bit k of set_i sets source k.
- R3: The vectors, in octal, are: 4 for sources 0, 1, 2, 5 and 12; 250 for 3; 114 for 4; 10 for 6; 14 for 7 and 11; 20 for 8; 30 for 9; 34 for 10; 24 for 13; 244 for 14.
- R4: While valid_o is 1 and ack_i is 0, grant_o and vec_o do not change. The cycle after an acknowledge, valid_o is 0.
- R5: Acknowledging a source removes these pending requests. Source 0 removes {0,1,2,3,4,11,12}. Source 1 removes {1,2,3,4,11,12}. Source 2 removes {2,3,4,11,12}. Source 3 removes {3,4,11,12}. Source 4 removes {4,11,12}. Sources 5 to 10 remove themselves and 11. Sources 11 to 14 remove only themselves.
- R6: A kernel stack abort pulse first removes the red-stack group {0,1,2,3,4,11,12} from the pending set, including sets arriving in the same cycle, and then makes source 0 pending.
- R7: clr_mmr1_o is 1 exactly in a cycle where valid_o and ack_i are both 1 and mm_frozen_i is 0.
- R8: ld_mmr2_o is 1 when clr_mmr1_o is 1 and the granted source is 0 to 4, 11 to 14, or the interrupt. It is never 1 for sources 5 to 10.
- R9: When no trap is pending and irq_i is 1, the grant is index 15 with vector irq_vec_i. Acknowledging it clears no trap.
- R10: A set pulse in the same cycle as an acknowledge survives the clear of that acknowledge.
- R11: ack_i while valid_o is 0 has no effect and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| set_i | input | 15 | Per-source request set pulses |
| kstk_abort_i | input | 1 | Kernel stack abort event |
| ack_i | input | 1 | Sequencer accepts the offered grant |
| mm_frozen_i | input | 1 | Memory-management registers frozen |
| irq_i | input | 1 | External interrupt request |
| irq_vec_i | input | VEC_W | External interrupt vector |
| valid_o | output | 1 | A grant is offered |
| grant_o | output | 4 | Granted index, 15 for interrupt |
| vec_o | output | VEC_W | Vector of the granted request |
| clr_mmr1_o | output | 1 | Clear the instruction-tracking register |
| ld_mmr2_o | output | 1 | Load the vector into the vector-capture register |

## Verification
The bench builds the block with the default VEC_W of 16. This lets an interrupt vector above the trap range (octal 300) pass through unaltered. The bench sweeps every one of the fifteen source indices, so each vector and each capture-mask bit is seen. Because the clear groups are not ports, the bench observes them through the sequence of later grants. It also hits the corner cases of a stack abort arriving with other sets, a set arriving during an acknowledge, and a stray acknowledge.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
    localparam int NSRC  = 15;
    localparam int IDX_W = $clog2(NSRC + 1);
    localparam int IRQ_IDX = NSRC;

    localparam int S_RED = 0;
    localparam int S_ODD = 1;
    localparam int S_NXM = 2;
    localparam int S_MMU = 3;
    localparam int S_PAR = 4;
    localparam int S_PRV = 5;
    localparam int S_ILL = 6;
    localparam int S_BPT = 7;
    localparam int S_IOT = 8;
    localparam int S_EMT = 9;
    localparam int S_TRP = 10;
    localparam int S_TRC = 11;
    localparam int S_YEL = 12;
    localparam int S_PWR = 13;
    localparam int S_FPE = 14;

    function automatic logic [NSRC-1:0] bm(input int i);
        return NSRC'(1) << i;
    endfunction

    // vector of each source, octal
    function automatic logic [15:0] src_vector(input int i);
        case (i)
            S_MMU:        return 16'o250;
            S_PAR:        return 16'o114;
            S_ILL:        return 16'o10;
            S_BPT, S_TRC: return 16'o14;
            S_IOT:        return 16'o20;
            S_EMT:        return 16'o30;
            S_TRP:        return 16'o34;
            S_PWR:        return 16'o24;
            S_FPE:        return 16'o244;
            default:      return 16'o4;
        endcase
    endfunction

    // pending requests removed when source i is serviced (R5)
    function automatic logic [NSRC-1:0] src_clear(input int i);
        logic [NSRC-1:0] tail;
        tail = bm(S_PAR) | bm(S_YEL) | bm(S_TRC);
        case (i)
            S_RED: return bm(S_RED) | bm(S_ODD) | bm(S_NXM) | bm(S_MMU) | tail;
            S_ODD: return bm(S_ODD) | bm(S_NXM) | bm(S_MMU) | tail;
            S_NXM: return bm(S_NXM) | bm(S_MMU) | tail;
            S_MMU: return bm(S_MMU) | tail;
            S_PAR: return tail;
            S_PRV, S_ILL, S_BPT, S_IOT, S_EMT, S_TRP: return bm(i) | bm(S_TRC);
            default: return bm(i);
        endcase
    endfunction

    // does servicing source i capture the vector (R8)
    function automatic logic src_loads_mmr2(input int i);
        return !(i >= S_PRV && i <= S_TRP);
    endfunction
endpackage

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
    parameter int N     = 15,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/trap_src_lookup.sv
module trap_src_lookup
    import trap_arb_pkg::*;
#(
    parameter int N     = NSRC,
    parameter int IDX_W = 4,
    parameter int VEC_W = 16
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [VEC_W-1:0] vec_o,
    output logic [N-1:0]     clr_o,
    output logic             mmr2_o
);
    logic [VEC_W-1:0] vtab [N];
    logic [N-1:0]     ctab [N];
    logic [N-1:0]     mtab;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign vtab[g] = VEC_W'(src_vector(g));
        assign ctab[g] = N'(src_clear(g));
        assign mtab[g] = src_loads_mmr2(g);
    end

    always_comb begin
        vec_o  = '0;
        clr_o  = '0;
        mmr2_o = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (idx_i == IDX_W'(k)) begin
                vec_o  = vtab[k];
                clr_o  = ctab[k];
                mmr2_o = mtab[k];
            end
        end
    end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_arb_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NSRC-1:0]  set_i,
    input  logic             kstk_abort_i,
    input  logic             ack_i,
    input  logic             mm_frozen_i,
    input  logic             irq_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] grant_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             clr_mmr1_o,
    output logic             ld_mmr2_o
);
    localparam logic [IDX_W-1:0] IRQ_CODE = IDX_W'(IRQ_IDX);
    localparam logic [NSRC-1:0]  RED_GROUP = src_clear(S_RED);

    typedef struct packed {
        logic [NSRC-1:0]  pending;
        logic             valid;
        logic [IDX_W-1:0] grant;
        logic [VEC_W-1:0] vec;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic             cand_any;
    logic [IDX_W-1:0] cand_idx;
    logic [VEC_W-1:0] cand_vec;
    logic [NSRC-1:0]  cand_clr_unused;
    logic             cand_m2_unused;
    logic [VEC_W-1:0] gr_vec_unused;
    logic [NSRC-1:0]  gr_clr;
    logic             gr_m2;

    trap_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
        .req_i (st_q.pending),
        .any_o (cand_any),
        .idx_o (cand_idx)
    );

    trap_src_lookup #(.N(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_cand_tab (
        .idx_i  (cand_idx),
        .vec_o  (cand_vec),
        .clr_o  (cand_clr_unused),
        .mmr2_o (cand_m2_unused)
    );

    trap_src_lookup #(.N(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_grant_tab (
        .idx_i  (st_q.grant),
        .vec_o  (gr_vec_unused),
        .clr_o  (gr_clr),
        .mmr2_o (gr_m2)
    );

    logic            take_ack;
    logic            is_irq;
    logic [NSRC-1:0] pend;

    always_comb begin
        st_d       = st_q;
        take_ack   = st_q.valid & ack_i;
        is_irq     = (st_q.grant == IRQ_CODE);
        pend       = st_q.pending;
        clr_mmr1_o = 1'b0;
        ld_mmr2_o  = 1'b0;

        if (take_ack) begin
            if (!is_irq) begin
                pend = pend & ~gr_clr;
            end
            st_d.valid = 1'b0;
            clr_mmr1_o = ~mm_frozen_i;
            ld_mmr2_o  = ~mm_frozen_i & (is_irq | gr_m2);
        end

        pend = pend | set_i;
        if (kstk_abort_i) begin
            pend = (pend & ~RED_GROUP) | NSRC'(1);
        end
        st_d.pending = pend;

        if (!st_q.valid) begin
            if (cand_any) begin
                st_d.valid = 1'b1;
                st_d.grant = cand_idx;
                st_d.vec   = cand_vec;
            end else if (irq_i) begin
                st_d.valid = 1'b1;
                st_d.grant = IRQ_CODE;
                st_d.vec   = irq_vec_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign grant_o = st_q.grant;
    assign vec_o   = st_q.vec;
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk
    import trap_arb_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ack_i,
    input logic             mm_frozen_i,
    input logic             valid_o,
    input logic [IDX_W-1:0] grant_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             clr_mmr1_o,
    input logic             ld_mmr2_o
);
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && !ack_i |=> valid_o && $stable(grant_o) && $stable(vec_o));

    p_ack_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && ack_i |=> !valid_o);

    p_mmr1_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_mmr1_o |-> valid_o && ack_i && !mm_frozen_i);

    p_mmr1_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && ack_i && !mm_frozen_i |-> clr_mmr1_o);

    p_mmr2_sub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_mmr2_o |-> clr_mmr1_o);

    p_mmr2_inst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_mmr2_o |-> !(grant_o >= IDX_W'(S_PRV) && grant_o <= IDX_W'(S_TRP)));

    p_mmu_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o && grant_o == IDX_W'(S_MMU) |-> vec_o == VEC_W'(16'o250));

    p_stray_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> !clr_mmr1_o && !ld_mmr2_o);
endmodule

bind trap_arbiter trap_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .mm_frozen_i (mm_frozen_i),
    .valid_o     (valid_o),
    .grant_o     (grant_o),
    .vec_o       (vec_o),
    .clr_mmr1_o  (clr_mmr1_o),
    .ld_mmr2_o   (ld_mmr2_o)
);

// File: tb/trap_arbiter_test.sv
module trap_arbiter_test;
    localparam int VW = 16;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [14:0]   set_i = '0;
    logic          kstk_abort_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          mm_frozen_i = 1'b0;
    logic          irq_i = 1'b0;
    logic [VW-1:0] irq_vec_i = '0;
    logic          valid_o;
    logic [3:0]    grant_o;
    logic [VW-1:0] vec_o;
    logic          clr_mmr1_o;
    logic          ld_mmr2_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    trap_arbiter #(.VEC_W(VW)) uut (.*);

    always #5 clk_i = ~clk_i;

    function automatic int exp_vec(input int i);
        case (i)
            3: return 'o250;   4: return 'o114;  6: return 'o10;
            7, 11: return 'o14; 8: return 'o20;  9: return 'o30;
            10: return 'o34;   13: return 'o24;  14: return 'o244;
            default: return 'o4;
        endcase
    endfunction

    function automatic int exp_m2(input int i);
        return (i >= 5 && i <= 10) ? 0 : 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_set(input logic [14:0] m, input logic ks);
        set_i = m; kstk_abort_i = ks;
        @(negedge clk_i);
        set_i = '0; kstk_abort_i = 1'b0;
    endtask

    task automatic expect_grant(input string req, input int idx, input int vec);
        int n = 0;
        while (!valid_o && n < 40) begin
            @(negedge clk_i);
            n++;
        end
        chk({req, " valid"}, int'(valid_o), 1);
        chk({req, " grant"}, int'(grant_o), idx);
        chk({req, " vector"}, int'(vec_o), vec);
    endtask

    task automatic do_ack(input string req, input int m1, input int m2);
        ack_i = 1'b1;
        #1;
        chk({req, " clr_mmr1"}, int'(clr_mmr1_o), m1);
        chk({req, " ld_mmr2"}, int'(ld_mmr2_o), m2);
        @(negedge clk_i);
        ack_i = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        repeat (5) @(negedge clk_i);
        chk({req, " idle"}, int'(valid_o), 0);
    endtask

    task automatic t_reset;
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 clr_mmr1", int'(clr_mmr1_o), 0);
        chk("R1 ld_mmr2", int'(ld_mmr2_o), 0);
        expect_idle("R1");
    endtask

    task automatic t_priority_clear;
        pulse_set(15'(1 << 1 | 1 << 2 | 1 << 4 | 1 << 11 | 1 << 5), 1'b0);
        expect_grant("R2 odd first", 1, 'o4);
        repeat (3) @(negedge clk_i);
        chk("R4 hold grant", int'(grant_o), 1);
        chk("R4 hold vec", int'(vec_o), 'o4);
        do_ack("R8 odd", 1, 1);
        chk("R4 drop", int'(valid_o), 0);
        expect_grant("R5 odd clears nxm,par,trc", 5, 'o4);
        do_ack("R8 priv", 1, 0);
        expect_idle("R5 priv clears trace");
    endtask

    task automatic t_vectors;
        for (int i = 0; i < 15; i++) begin
            pulse_set(15'(1 << i), 1'b0);
            expect_grant("R3", i, exp_vec(i));
            do_ack("R8", 1, exp_m2(i));
        end
        expect_idle("R3");
    endtask

    task automatic t_group_order;
        pulse_set(15'(1 << 3 | 1 << 4 | 1 << 12 | 1 << 13), 1'b0);
        expect_grant("R2 mmu", 3, 'o250);
        do_ack("R7 mmu", 1, 1);
        expect_grant("R5 mmu clears par,yel", 13, 'o24);
        do_ack("R8 pwr", 1, 1);
        expect_idle("R5");
    endtask

    task automatic t_kstk;
        pulse_set(15'(1 << 3 | 1 << 4 | 1 << 5 | 1 << 14), 1'b1);
        expect_grant("R6 red", 0, 'o4);
        do_ack("R6 red", 1, 1);
        expect_grant("R6 priv survives", 5, 'o4);
        do_ack("R6 priv", 1, 0);
        expect_grant("R6 fpe survives", 14, 'o244);
        do_ack("R6 fpe", 1, 1);
        expect_idle("R6 mmu,par wiped");
    endtask

    task automatic t_frozen;
        mm_frozen_i = 1'b1;
        pulse_set(15'(1 << 4), 1'b0);
        expect_grant("R7 par", 4, 'o114);
        do_ack("R7 frozen", 0, 0);
        mm_frozen_i = 1'b0;
        expect_idle("R7");
    endtask

    task automatic t_irq;
        irq_vec_i = VW'('o300);
        irq_i = 1'b1;
        expect_grant("R9 irq", 15, 'o300);
        do_ack("R9 irq", 1, 1);
        irq_i = 1'b0;
        expect_idle("R9");
        pulse_set(15'(1 << 11), 1'b0);
        expect_grant("R9 trace before irq", 11, 'o14);
        irq_i = 1'b1;
        do_ack("R9 trace", 1, 1);
        expect_grant("R9 irq after trap", 15, 'o300);
        do_ack("R9 irq2", 1, 1);
        irq_i = 1'b0;
        expect_idle("R9");
    endtask

    task automatic t_same_cycle;
        pulse_set(15'(1 << 4), 1'b0);
        expect_grant("R10 par", 4, 'o114);
        set_i = 15'(1 << 4);
        do_ack("R10 par", 1, 1);
        set_i = '0;
        expect_grant("R10 set kept", 4, 'o114);
        do_ack("R10 par again", 1, 1);
        expect_idle("R10");
    endtask

    task automatic t_stray_ack;
        do_ack("R11 stray", 0, 0);
        expect_idle("R11");
        pulse_set(15'(1 << 7), 1'b0);
        expect_grant("R11 after stray", 7, 'o14);
        do_ack("R11 bpt", 1, 0);
        expect_idle("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset;
        t_priority_clear;
        t_vectors;
        t_group_order;
        t_kstk;
        t_frozen;
        t_irq;
        t_same_cycle;
        t_stray_ack;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule